// File: doc/BRIEF.md
# Shared-Rail Frequency and Voltage Sequencer

This block picks one operating point (a frequency code and a supply voltage code) for a group of cores that share a clock and a supply rail. Each core presents a requested performance level and an active flag. The sequencer takes the highest level asked for by any active core. It works out the supply voltage that level needs for the current number of active cores, then moves the rail and the clock generator to the new point in a safe order.

Voltage never jumps. It moves one code at a time, and each step waits for the regulator to acknowledge the previous one. When the clock speeds up, the rail is brought to its new level first and the frequency follows. When the clock slows down, the frequency changes first and the rail follows once the clock generator reports lock. Requests that arrive while a change is under way are not lost. Inputs are levels, so the point in force when the sequencer returns to idle is the one it acts on next.

Top module: `dvfs_seq`

## Requirements
- R1: The chosen frequency code is the largest `req_level` field among cores whose `core_active` bit is 1. Fields of inactive cores never affect the choice. Core c uses bits [c*FREQ_W +: FREQ_W].
- R2: While no core is active, `freq_code` and `volt_code` hold their values and `busy` stays 0, whatever the requests are.
- R3: The settled voltage code is 20 + 8*f + 2*(n-1), where f is the chosen frequency code and n is the count of active cores (n >= 1).
- R4: On a move to a higher frequency code, `volt_code` reaches its final value before `freq_code` changes.
- R5: On a move to a lower frequency code, `freq_code` changes while `volt_code` still holds its pre-transition value. The voltage moves only after that.
- R6: `volt_code` changes by exactly one per step. After a step it does not change again until a one-cycle `vr_ack` pulse has been received.
- R7: After `freq_code` changes, the transition does not continue (no voltage step, no return to idle) until `pll_lock` is seen high in a later cycle.
- R8: Request changes made while `busy` is 1 do not alter the transition in progress. When it ends, the newest inputs start the next transition.
- R9: `busy` goes to 1 in the cycle after the inputs resolve to a point that differs from the current one. It returns to 0 when the last step completes. If the resolved point equals the current one, `busy` stays 0.
- R10: After reset, `freq_code` is 0, `volt_code` is 20 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_level | input | NUM_CORES*FREQ_W | Requested level per core, packed |
| core_active | input | NUM_CORES | Per-core active flag |
| vr_ack | input | 1 | Regulator step acknowledge, one-cycle pulse |
| pll_lock | input | 1 | Clock generator lock indication |
| volt_code | output | VOLT_W | Supply voltage code to regulator |
| freq_code | output | FREQ_W | Frequency code to clock generator |
| busy | output | 1 | Transition in progress |

## Verification
Suppose the sequencer held a wrong target or a wrong phase. It would show at the ports within one step as one of three things: a voltage code that moves by more than one, a voltage code that moves without an acknowledge, or a frequency code that changes while the rail is not at the required level. A wrong lookup or a wrong core count appears as a wrong settled pair as soon as `busy` drops. The bench sweeps request patterns and every non-empty active mask, and computes each settled point arithmetically. A lost or early deferred request shows up as a wrong point at the first idle, or as no second busy period.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_V_FIRST = 2'd1,
        ST_F_WAIT  = 2'd2,
        ST_V_LAST  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/dvfs_arbiter.sv
module dvfs_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int FREQ_W    = 3,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic [NUM_CORES*FREQ_W-1:0] req_level,
    input  logic [NUM_CORES-1:0]        core_active,
    output logic [FREQ_W-1:0]           max_level,
    output logic [CNT_W-1:0]            n_active,
    output logic                        any_active
);
    always_comb begin
        max_level = '0;
        n_active  = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core_active[c]) begin
                n_active = n_active + CNT_W'(1);
                if (req_level[c*FREQ_W +: FREQ_W] > max_level)
                    max_level = req_level[c*FREQ_W +: FREQ_W];
            end
        end
        any_active = |core_active;
    end
endmodule

// File: rtl/dvfs_vtarget.sv
module dvfs_vtarget #(
    parameter int NUM_CORES  = 4,
    parameter int FREQ_W     = 3,
    parameter int VOLT_W     = 8,
    parameter int V_BASE     = 20,
    parameter int V_SLOPE    = 8,
    parameter int V_CORE_OFS = 2,
    localparam int CNT_W     = $clog2(NUM_CORES + 1),
    localparam int LEVELS    = 1 << FREQ_W
) (
    input  logic [FREQ_W-1:0] level,
    input  logic [CNT_W-1:0]  n_active,
    output logic [VOLT_W-1:0] v_target
);
    logic [VOLT_W-1:0] vtab [LEVELS];
    logic [VOLT_W-1:0] extra;

    for (genvar g = 0; g < LEVELS; g++) begin : g_vtab
        assign vtab[g] = VOLT_W'(V_BASE + V_SLOPE * g);
    end

    always_comb begin
        if (n_active == '0) extra = '0;
        else                extra = VOLT_W'(V_CORE_OFS * (int'(n_active) - 1));
        v_target = vtab[level] + extra;
    end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int FREQ_W     = 3,
    parameter int VOLT_W     = 8,
    parameter int V_BASE     = 20,
    parameter int V_SLOPE    = 8,
    parameter int V_CORE_OFS = 2,
    parameter int RST_FREQ   = 0,
    localparam int CNT_W     = $clog2(NUM_CORES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES*FREQ_W-1:0] req_level,
    input  logic [NUM_CORES-1:0]        core_active,
    input  logic                        vr_ack,
    input  logic                        pll_lock,
    output logic [VOLT_W-1:0]           volt_code,
    output logic [FREQ_W-1:0]           freq_code,
    output logic                        busy
);
    localparam logic [FREQ_W-1:0] RST_F = FREQ_W'(RST_FREQ);
    localparam logic [VOLT_W-1:0] RST_V = VOLT_W'(V_BASE + V_SLOPE * RST_FREQ);

    typedef struct packed {
        seq_st_e           st;
        logic [FREQ_W-1:0] f;
        logic [VOLT_W-1:0] v;
        logic [FREQ_W-1:0] tf;
        logic [VOLT_W-1:0] tv;
        logic              wait_ack;
        logic              fresh;
    } seq_s;

    seq_s q, d;

    logic [FREQ_W-1:0] arb_f;
    logic [CNT_W-1:0]  arb_n;
    logic              any_act;
    logic [VOLT_W-1:0] arb_v;

    dvfs_arbiter #(.NUM_CORES(NUM_CORES), .FREQ_W(FREQ_W)) u_arb (
        .req_level  (req_level),
        .core_active(core_active),
        .max_level  (arb_f),
        .n_active   (arb_n),
        .any_active (any_act)
    );

    dvfs_vtarget #(
        .NUM_CORES(NUM_CORES), .FREQ_W(FREQ_W), .VOLT_W(VOLT_W),
        .V_BASE(V_BASE), .V_SLOPE(V_SLOPE), .V_CORE_OFS(V_CORE_OFS)
    ) u_vt (
        .level   (arb_f),
        .n_active(arb_n),
        .v_target(arb_v)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (any_act && (arb_f != q.f || arb_v != q.v)) begin
                    d.tf       = arb_f;
                    d.tv       = arb_v;
                    d.wait_ack = 1'b0;
                    if (arb_f > q.f) begin
                        d.st = ST_V_FIRST;
                    end else if (arb_f < q.f) begin
                        d.f     = arb_f;
                        d.fresh = 1'b1;
                        d.st    = ST_F_WAIT;
                    end else begin
                        d.st = ST_V_LAST;
                    end
                end
            end
            ST_V_FIRST, ST_V_LAST: begin
                if (q.wait_ack) begin
                    if (vr_ack) d.wait_ack = 1'b0;
                end else if (q.v != q.tv) begin
                    d.v        = (q.v < q.tv) ? q.v + VOLT_W'(1) : q.v - VOLT_W'(1);
                    d.wait_ack = 1'b1;
                end else if (q.st == ST_V_FIRST) begin
                    d.f     = q.tf;
                    d.fresh = 1'b1;
                    d.st    = ST_F_WAIT;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_F_WAIT: begin
                if (q.fresh)       d.fresh = 1'b0;
                else if (pll_lock) d.st = (q.v != q.tv) ? ST_V_LAST : ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, f: RST_F, v: RST_V, tf: RST_F, tv: RST_V,
                   wait_ack: 1'b0, fresh: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign volt_code = q.v;
    assign freq_code = q.f;
    assign busy      = (q.st != ST_IDLE);

    // Rail moves one code at a time, and only after the previous step was acknowledged
    assert_volt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (volt_code != $past(volt_code)) |->
            (!$past(q.wait_ack) &&
             (volt_code == $past(volt_code) + VOLT_W'(1) ||
              volt_code == $past(volt_code) - VOLT_W'(1))));

    // Frequency rises only once the rail sits at its target
    assert_up_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code > $past(freq_code)) |->
            (volt_code == q.tv && $past(q.st) == ST_V_FIRST));

    // Frequency drops straight out of idle, before any rail step
    assert_dn_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_code < $past(freq_code)) |->
            ($past(q.st) == ST_IDLE && $stable(volt_code)));

    // Leaving the lock wait needs a lock seen after the settle cycle
    assert_lock_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_F_WAIT && q.st != ST_F_WAIT) |->
            ($past(pll_lock) && !$past(q.fresh)));

    // Idle means both codes are held
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(freq_code) && $stable(volt_code)));

    // With no active core, no transition starts
    assert_no_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !any_act) |=> (q.st == ST_IDLE));
endmodule

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb;
    localparam int NC  = 4;
    localparam int FW  = 3;
    localparam int VW  = 8;
    localparam int ACK_DLY  = 2;
    localparam int LOCK_DLY = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NC*FW-1:0] req_level = '0;
    logic [NC-1:0]  core_active = '0;
    logic           vr_ack = 1'b0;
    logic           pll_lock = 1'b1;
    logic [VW-1:0]  volt_code;
    logic [FW-1:0]  freq_code;
    logic           busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // transition context for the order monitor
    bit mon_en = 1'b0;
    int exp_f, exp_v, tr_f0, tr_v0;

    // monitor and model state
    int  last_f = 0, last_v = 20, fcyc = 0;
    bit  last_busy = 1'b0, fchg = 1'b0, ack_seen = 1'b1;
    int  reg_v = 20, rcnt = 0, pll_f = 0, pcnt = 0;

    always #5 clk = ~clk;

    dvfs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_level(req_level), .core_active(core_active),
        .vr_ack(vr_ack), .pll_lock(pll_lock), .volt_code(volt_code),
        .freq_code(freq_code), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            finish_run();
        end
    end

    // monitor first, then regulator and clock generator models
    always @(negedge clk) begin
        if (rst_n) begin
            if (!last_busy && busy) fchg = 1'b0;
            if (int'(volt_code) != last_v) begin
                chk(ack_seen, "R6 step without ack", 0, 1);
                chk(int'(volt_code) - last_v == 1 || last_v - int'(volt_code) == 1,
                    "R6 step size", int'(volt_code), last_v);
                if (mon_en && exp_f < tr_f0)
                    chk(int'(freq_code) == exp_f, "R5 volt before freq", int'(freq_code), exp_f);
                if (fchg) chk(fcyc > LOCK_DLY, "R7 volt step before lock", fcyc, LOCK_DLY + 1);
                ack_seen = 1'b0;
            end
            if (int'(freq_code) != last_f) begin
                if (mon_en && exp_f > tr_f0)
                    chk(int'(volt_code) == exp_v, "R4 freq up before volt", int'(volt_code), exp_v);
                if (mon_en && exp_f < tr_f0)
                    chk(int'(volt_code) == tr_v0, "R5 freq down after volt", int'(volt_code), tr_v0);
                fchg = 1'b1;
                fcyc = 0;
            end else begin
                fcyc++;
            end
            if (last_busy && !busy && fchg)
                chk(fcyc > LOCK_DLY, "R7 done before lock", fcyc, LOCK_DLY + 1);
            if (vr_ack) ack_seen = 1'b1;
            last_f = int'(freq_code);
            last_v = int'(volt_code);
            last_busy = busy;
            // regulator
            if (int'(volt_code) != reg_v) begin
                reg_v = int'(volt_code); rcnt = ACK_DLY; vr_ack = 1'b0;
            end else if (rcnt > 0) begin
                rcnt--; vr_ack = (rcnt == 0);
            end else begin
                vr_ack = 1'b0;
            end
            // clock generator
            if (int'(freq_code) != pll_f) begin
                pll_f = int'(freq_code); pcnt = LOCK_DLY; pll_lock = 1'b0;
            end else if (pcnt > 0) begin
                pcnt--; if (pcnt == 0) pll_lock = 1'b1;
            end
        end
    end

    // expected point from the requirements (R1, R3); keeps old point if none active
    task automatic calc_exp(input int rq[NC], input logic [NC-1:0] m);
        int f = 0, n = 0;
        for (int c = 0; c < NC; c++) if (m[c]) begin n++; if (rq[c] > f) f = rq[c]; end
        if (n > 0) begin exp_f = f; exp_v = 20 + 8 * f + 2 * (n - 1); end
        else begin exp_f = int'(freq_code); exp_v = int'(volt_code); end
    endtask

    task automatic drive(input int rq[NC], input logic [NC-1:0] m);
        for (int c = 0; c < NC; c++) req_level[c*FW +: FW] = FW'(rq[c]);
        core_active = m;
    endtask

    task automatic run_to_idle();
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
    endtask

    // apply inputs at a negedge, run the transition, check the settled point
    task automatic step_point(input int rq[NC], input logic [NC-1:0] m, input string tag);
        bit moves;
        tr_f0 = int'(freq_code); tr_v0 = int'(volt_code);
        calc_exp(rq, m);
        moves = (exp_f != tr_f0 || exp_v != tr_v0);
        drive(rq, m);
        @(negedge clk);
        chk(busy == moves, {tag, " R9 busy start"}, int'(busy), int'(moves));
        run_to_idle();
        chk(int'(freq_code) == exp_f, {tag, " R1 freq"}, int'(freq_code), exp_f);
        chk(int'(volt_code) == exp_v, {tag, " R3 volt"}, int'(volt_code), exp_v);
    endtask

    initial begin
        int rq[NC];
        int hf, hv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(freq_code == 0, "R10 reset freq", int'(freq_code), 0);
        chk(volt_code == 20, "R10 reset volt", int'(volt_code), 20);
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);

        // R2: no active core, requests change, nothing moves
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < NC; c++) rq[c] = (k + c * 3 + 1) % 8;
            drive(rq, '0);
            repeat (4) @(negedge clk);
            chk(busy == 1'b0, "R2 busy idle", int'(busy), 0);
            chk(freq_code == 0 && volt_code == 20, "R2 point held", int'(volt_code), 20);
        end

        mon_en = 1'b1;
        // R4: straight up to the top level, all cores
        for (int c = 0; c < NC; c++) rq[c] = 7;
        step_point(rq, 4'hF, "R4 up");
        // R5: straight down to the lowest level, one core
        for (int c = 0; c < NC; c++) rq[c] = 0;
        step_point(rq, 4'h1, "R5 down");
        // R9: same point again, no transition
        step_point(rq, 4'h1, "R9 equal");
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R9 equal stays idle", int'(busy), 0);
        // R1: inactive core asks high, must be ignored
        rq[0] = 2; rq[1] = 7; rq[2] = 1; rq[3] = 7;
        step_point(rq, 4'b0101, "R1 inactive ignored");
        // R3: same level, more cores raises only the voltage
        rq[0] = 2; rq[1] = 2; rq[2] = 2; rq[3] = 2;
        step_point(rq, 4'hF, "R3 core count");

        // sweep of request patterns over every non-empty mask
        for (int s = 0; s < 8; s++) begin
            for (int m = 1; m < 16; m++) begin
                for (int c = 0; c < NC; c++) rq[c] = (s * 3 + c * 5 + m) % 8;
                step_point(rq, 4'(m), "sweep");
            end
        end

        // R8: deferral of requests made during a transition
        mon_en = 1'b0;
        for (int c = 0; c < NC; c++) rq[c] = 0;
        drive(rq, 4'h1); @(negedge clk); run_to_idle();
        for (int c = 0; c < NC; c++) rq[c] = 7;
        calc_exp(rq, 4'hF); hf = exp_f; hv = exp_v;
        drive(rq, 4'hF);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R8 first transition running", int'(busy), 1);
        for (int c = 0; c < NC; c++) rq[c] = 2;
        drive(rq, 4'h3);
        repeat (4) @(negedge clk);
        rq[0] = 5;
        drive(rq, 4'h1);
        run_to_idle();
        chk(int'(freq_code) == hf, "R8 first target freq", int'(freq_code), hf);
        chk(int'(volt_code) == hv, "R8 first target volt", int'(volt_code), hv);
        @(negedge clk);
        chk(busy == 1'b1, "R8 deferred start", int'(busy), 1);
        run_to_idle();
        chk(freq_code == 5, "R8 newest freq", int'(freq_code), 5);
        chk(volt_code == 60, "R8 newest volt", int'(volt_code), 60);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule